// File: doc/BRIEF.md
# DMA Channel Address Pointer Unit

This block keeps the two address pointers of a single DMA channel, one for the source and one for the destination, and moves each of them after every transfer it takes part in. Control inputs from the channel's control register decide how each pointer moves. Each pointer has an increment bit and a decrement bit, and it moves only when exactly one of the two is set. A width bit picks the step: one for byte transfers, two for word transfers. A space bit for each pointer marks its target as memory or I/O.

During a fetch phase the block puts the source pointer on the address output. During a deposit phase it puts the destination pointer there. Alongside the address it drives a memory-or-I/O indicator. The source pointer advances at the end of a fetch cycle and the destination pointer at the end of a deposit cycle.

Software reaches the pointers through a small register port. Each 20-bit pointer is split into a 16-bit low half and a 4-bit high half, and both halves can be written and read back. A software write always wins over an automatic update that falls in the same cycle.

Top module: `dma_ptr_unit`

## Requirements
- R1: After reset both pointers read as zero. With no phase active, `addr_o` is zero and `mem_o` is 0.
- R2: Register index on `reg_addr_i`: 0 is the source low half, 1 the source high half, 2 the destination low half, 3 the destination high half. A write stores `reg_wdata_i[15:0]` into a low half, or only `reg_wdata_i[3:0]` into a high half. `reg_rdata_o` returns the selected half, zero-extended, in the same cycle.
- R3: When `fetch_i` is 1, `addr_o` carries the source pointer and `mem_o` equals `src_mem_i`. When `fetch_i` is 0 and `deposit_i` is 1, they carry the destination pointer and `dst_mem_i`. When neither is 1, both are zero. Fetch takes precedence when both are 1.
- R4: If a pointer's increment bit is 1 and its decrement bit is 0, the pointer grows by the step at the clock edge that ends its phase cycle (fetch for source, deposit for destination). The new value is visible from the next cycle on.
- R5: If a pointer's decrement bit is 1 and its increment bit is 0, the pointer shrinks by the step at that same edge.
- R6: If a pointer's increment and decrement bits are equal (both 0 or both 1), the pointer does not change after its phase.
- R7: The step is 1 when `word_i` is 0 (byte) and 2 when `word_i` is 1 (word).
- R8: A carry or borrow out of the low half moves into the high half. The whole 20-bit pointer wraps modulo 2^20.
- R9: A space bit of 1 means memory and 0 means I/O. When the selected pointer is in I/O space, `addr_o[19:16]` is driven as zero.
- R10: A write to either half of a pointer in a cycle where that pointer would advance takes priority. The written half takes the write data, the other half keeps its old value, and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Pointer half select (see R2) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected half |
| word_i | input | 1 | 1 = word transfers, 0 = byte |
| src_inc_i | input | 1 | Source increment bit |
| src_dec_i | input | 1 | Source decrement bit |
| src_mem_i | input | 1 | Source space, 1 = memory, 0 = I/O |
| dst_inc_i | input | 1 | Destination increment bit |
| dst_dec_i | input | 1 | Destination decrement bit |
| dst_mem_i | input | 1 | Destination space, 1 = memory, 0 = I/O |
| fetch_i | input | 1 | Fetch phase active this cycle |
| deposit_i | input | 1 | Deposit phase active this cycle |
| addr_o | output | 20 | Transfer address |
| mem_o | output | 1 | Space of `addr_o`, 1 = memory |

## Verification
The bench drives both hold encodings in byte and word mode. A design that treats "both set" as a step would drift where it should stay put. It steps across the 16-bit half boundary and across the 20-bit wrap in both directions, which catches a carry that is lost or misrouted into the high half. It lines up software writes with phase cycles, where a wrong priority shows up as a stepped value after a write. It also drives fetch and deposit together with I/O space selected, so a wrong phase precedence or stray upper address bits appear on `addr_o` at once.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;
  parameter int PTR_W = 20;
  parameter int LO_W  = 16;

  typedef enum logic [1:0] {
    REG_SRC_LO = 2'd0,
    REG_SRC_HI = 2'd1,
    REG_DST_LO = 2'd2,
    REG_DST_HI = 2'd3
  } ptr_reg_e;
endpackage

// File: rtl/dma_ptr_reg.sv
module dma_ptr_reg #(
  parameter int PTR_W = 20,
  parameter int LO_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [LO_W-1:0]  wdata_i,
  input  logic             adv_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             word_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam int HI_W = PTR_W - LO_W;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] step;
  logic             move;

  assign step = word_i ? PTR_W'(2) : PTR_W'(1);
  assign move = adv_i && (inc_i ^ dec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      // software write blocks the automatic step this cycle
      if (wr_lo_i) ptr_q[LO_W-1:0]     <= wdata_i;
      if (wr_hi_i) ptr_q[PTR_W-1:LO_W] <= wdata_i[HI_W-1:0];
    end else if (move) begin
      ptr_q <= dec_i ? ptr_q - step : ptr_q + step;
    end
  end

  assign ptr_o = ptr_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (inc_i == dec_i) && !wr_lo_i && !wr_hi_i) |=> $stable(ptr_q));

  assert_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && inc_i && !dec_i && !wr_lo_i && !wr_hi_i)
    |=> ptr_q == PTR_W'($past(ptr_q) + ($past(word_i) ? 2 : 1)));

  assert_dec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && dec_i && !inc_i && !wr_lo_i && !wr_hi_i)
    |=> ptr_q == PTR_W'($past(ptr_q) - ($past(word_i) ? 2 : 1)));

  assert_wr_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (ptr_q[LO_W-1:0] == $past(wdata_i)) &&
                               (ptr_q[PTR_W-1:LO_W] == $past(ptr_q[PTR_W-1:LO_W])));
endmodule

// File: rtl/dma_addr_mux.sv
module dma_addr_mux #(
  parameter int PTR_W = 20,
  parameter int LO_W  = 16
) (
  input  logic             fetch_i,
  input  logic             deposit_i,
  input  logic [PTR_W-1:0] src_ptr_i,
  input  logic [PTR_W-1:0] dst_ptr_i,
  input  logic             src_mem_i,
  input  logic             dst_mem_i,
  output logic [PTR_W-1:0] addr_o,
  output logic             mem_o
);
  logic [PTR_W-1:0] sel_ptr;
  logic             sel_mem;
  logic             active;

  always_comb begin
    active  = fetch_i || deposit_i;
    sel_ptr = fetch_i ? src_ptr_i : dst_ptr_i;
    sel_mem = fetch_i ? src_mem_i : dst_mem_i;
    addr_o  = '0;
    mem_o   = 1'b0;
    if (active) begin
      mem_o               = sel_mem;
      addr_o[LO_W-1:0]    = sel_ptr[LO_W-1:0];
      // I/O space: upper address lines held low
      addr_o[PTR_W-1:LO_W] = sel_mem ? sel_ptr[PTR_W-1:LO_W] : '0;
    end
  end
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
  import dma_ptr_pkg::*;
#(
  parameter int PW = PTR_W,
  parameter int LW = LO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [LW-1:0] reg_wdata_i,
  output logic [LW-1:0] reg_rdata_o,
  input  logic          word_i,
  input  logic          src_inc_i,
  input  logic          src_dec_i,
  input  logic          src_mem_i,
  input  logic          dst_inc_i,
  input  logic          dst_dec_i,
  input  logic          dst_mem_i,
  input  logic          fetch_i,
  input  logic          deposit_i,
  output logic [PW-1:0] addr_o,
  output logic          mem_o
);
  localparam int NPTR = 2;

  logic [NPTR-1:0] inc_v, dec_v, adv_v;
  logic [PW-1:0]   ptr_v [NPTR];

  assign inc_v = {dst_inc_i, src_inc_i};
  assign dec_v = {dst_dec_i, src_dec_i};
  assign adv_v = {deposit_i, fetch_i};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic wr_lo, wr_hi;
    assign wr_lo = reg_we_i && (reg_addr_i == 2'(2 * g));
    assign wr_hi = reg_we_i && (reg_addr_i == 2'(2 * g + 1));

    dma_ptr_reg #(.PTR_W(PW), .LO_W(LW)) u_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .wdata_i (reg_wdata_i),
      .adv_i   (adv_v[g]),
      .inc_i   (inc_v[g]),
      .dec_i   (dec_v[g]),
      .word_i  (word_i),
      .ptr_o   (ptr_v[g])
    );
  end

  always_comb begin
    unique case (ptr_reg_e'(reg_addr_i))
      REG_SRC_LO: reg_rdata_o = ptr_v[0][LW-1:0];
      REG_SRC_HI: reg_rdata_o = LW'(ptr_v[0][PW-1:LW]);
      REG_DST_LO: reg_rdata_o = ptr_v[1][LW-1:0];
      default:    reg_rdata_o = LW'(ptr_v[1][PW-1:LW]);
    endcase
  end

  dma_addr_mux #(.PTR_W(PW), .LO_W(LW)) u_mux (
    .fetch_i   (fetch_i),
    .deposit_i (deposit_i),
    .src_ptr_i (ptr_v[0]),
    .dst_ptr_i (ptr_v[1]),
    .src_mem_i (src_mem_i),
    .dst_mem_i (dst_mem_i),
    .addr_o    (addr_o),
    .mem_o     (mem_o)
  );

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_i && !deposit_i) |-> (addr_o == '0) && !mem_o);

  assert_io_upper_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fetch_i && !src_mem_i) || (!fetch_i && deposit_i && !dst_mem_i))
    |-> (addr_o[PW-1:LW] == '0) && !mem_o);

  assert_fetch_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> (addr_o[LW-1:0] == ptr_v[0][LW-1:0]) && (mem_o == src_mem_i));
endmodule

// File: tb/dma_ptr_unit_bench.sv
`timescale 1ns/1ps
module dma_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  raddr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        word = 1'b0;
  logic        s_inc = 1'b0, s_dec = 1'b0, s_mem = 1'b1;
  logic        d_inc = 1'b0, d_dec = 1'b0, d_mem = 1'b1;
  logic        fetch = 1'b0, deposit = 1'b0;
  logic [19:0] addr;
  logic        mem;

  int checks = 0;
  int errors = 0;
  int src_m = 0;
  int dst_m = 0;
  int rot = 0;
  localparam int MASK = 20'hFFFFF;

  always #2.5 clk = ~clk;

  dma_ptr_unit u_dma_ptr_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .word_i(word),
    .src_inc_i(s_inc), .src_dec_i(s_dec), .src_mem_i(s_mem),
    .dst_inc_i(d_inc), .dst_dec_i(d_dec), .dst_mem_i(d_mem),
    .fetch_i(fetch), .deposit_i(deposit), .addr_o(addr), .mem_o(mem)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int step_ptr(int p, logic inc, logic dec);
    int st = word ? 2 : 1;
    if (inc && !dec) return (p + st) & MASK;
    if (dec && !inc) return (p - st) & MASK;
    return p;
  endfunction

  function automatic int wr_half(int p, logic hi);
    if (hi) return (p & 16'hFFFF) | ((int'(wdata) & 4'hF) << 16);
    return (p & 20'hF0000) | int'(wdata);
  endfunction

  // one clock: compare outputs at mid-cycle, then advance the model
  task automatic cyc(int n, string tag, bit rotate = 1'b1);
    for (int i = 0; i < n; i++) begin
      int ea, em, er, sel;
      if (rotate && !we) raddr = 2'(rot++);
      #1;
      sel = fetch ? src_m : dst_m;
      em  = fetch ? int'(s_mem) : (deposit ? int'(d_mem) : 0);
      ea  = (fetch || deposit) ? (em != 0 ? sel : (sel & 16'hFFFF)) : 0;
      case (raddr)
        2'd0: er = src_m & 16'hFFFF;
        2'd1: er = src_m >> 16;
        2'd2: er = dst_m & 16'hFFFF;
        default: er = dst_m >> 16;
      endcase
      check(tag, "addr_o", int'(addr), ea);
      check(tag, "mem_o", int'(mem), em);
      check(tag, "reg_rdata_o", int'(rdata), er);
      @(posedge clk);
      if (we && raddr[1] == 1'b0) src_m = wr_half(src_m, raddr[0]);
      else if (fetch) src_m = step_ptr(src_m, s_inc, s_dec);
      if (we && raddr[1] == 1'b1) dst_m = wr_half(dst_m, raddr[0]);
      else if (deposit) dst_m = step_ptr(dst_m, d_inc, d_dec);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, string tag);
    we = 1'b1; raddr = a; wdata = d;
    cyc(1, tag, 1'b0);
    we = 1'b0;
  endtask

  task automatic idle_reads(string tag);
    fetch = 1'b0; deposit = 1'b0;
    cyc(4, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "addr_o in reset", int'(addr), 0);
    check("R1", "mem_o in reset", int'(mem), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_reads("R1");

    // R2: writes and zero-extended readback, high half keeps 4 bits
    wr(2'd0, 16'h1234, "R2");
    wr(2'd1, 16'hFFF5, "R2");
    wr(2'd2, 16'hABCD, "R2");
    wr(2'd3, 16'h0007, "R2");
    idle_reads("R2");

    // R3/R4/R7: source increments by 1 in byte mode, by 2 in word mode
    s_inc = 1; s_dec = 0; s_mem = 1; word = 0; fetch = 1;
    cyc(3, "R4_R7_byte");
    word = 1;
    cyc(3, "R4_R7_word");
    // R5: decrement
    s_inc = 0; s_dec = 1;
    cyc(2, "R5_word");
    word = 0;
    cyc(2, "R5_byte");
    // R6: both hold encodings, both widths
    s_inc = 0; s_dec = 0; cyc(2, "R6_00_byte");
    s_inc = 1; s_dec = 1; cyc(2, "R6_11_byte");
    word = 1; cyc(2, "R6_11_word");
    s_inc = 0; s_dec = 0; cyc(2, "R6_00_word");
    fetch = 0;

    // R3: deposit drives destination, fetch wins when both set
    d_inc = 1; d_dec = 0; d_mem = 1; deposit = 1; word = 0;
    cyc(3, "R3_deposit");
    d_inc = 0; d_dec = 1; word = 1;
    cyc(2, "R5_dst");
    fetch = 1; s_inc = 1; s_dec = 0;
    cyc(3, "R3_both");
    fetch = 0; deposit = 0;
    idle_reads("R3_idle");

    // R9: I/O space masks the upper bits
    s_mem = 0; d_mem = 0; fetch = 1;
    cyc(2, "R9_src_io");
    fetch = 0; deposit = 1;
    cyc(2, "R9_dst_io");
    fetch = 1; s_mem = 1;
    cyc(2, "R9_mixed");
    fetch = 0; deposit = 0; d_mem = 1;

    // R8: carry into high half and 20-bit wrap
    wr(2'd0, 16'hFFFF, "R8"); wr(2'd1, 16'h0000, "R8");
    fetch = 1; s_inc = 1; s_dec = 0; word = 0;
    cyc(2, "R8_carry");
    s_inc = 0; s_dec = 1; word = 1;
    cyc(2, "R8_borrow");
    fetch = 0;
    wr(2'd0, 16'hFFFF, "R8"); wr(2'd1, 16'h000F, "R8");
    fetch = 1; s_inc = 1; s_dec = 0; word = 1;
    cyc(2, "R8_wrap_up");
    s_inc = 0; s_dec = 1; word = 0;
    cyc(3, "R8_wrap_down");
    fetch = 0;
    wr(2'd2, 16'h0000, "R8"); wr(2'd3, 16'h0000, "R8");
    deposit = 1; d_inc = 0; d_dec = 1; word = 0;
    cyc(2, "R8_dst_wrap");
    deposit = 0;
    idle_reads("R8");

    // R10: write during an advancing phase takes priority
    fetch = 1; s_inc = 1; s_dec = 0; word = 1;
    wr(2'd0, 16'h4000, "R10_src_lo");
    wr(2'd1, 16'h0003, "R10_src_hi");
    fetch = 0; deposit = 1; d_inc = 1; d_dec = 0;
    wr(2'd2, 16'h00FE, "R10_dst_lo");
    wr(2'd3, 16'h0009, "R10_dst_hi");
    deposit = 0;
    idle_reads("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule